// File: doc/BRIEF.md
# Extended Target Address Generator

This block resolves the operand of a 3-byte or 4-byte memory-reference instruction. It receives the addressing flags and the address fields of one instruction, together with the address of that instruction and the low 20 bits of the base register and the index register. From six flag bits it works out four things: the instruction length, the target address, any illegal flag combination, and what the operand is. The operand is either an immediate value, a plain operand address, or an operand address that is fetched from memory through one level of indirection.

An instruction is offered with a valid/ready handshake. The decoded result is held on the output side until the consumer accepts it. When an indirect reference is needed, the block issues one word-read request through its own valid/ready request channel. It then waits for the response, whose low 20 bits become the operand address. The block handles one instruction at a time. All address arithmetic wraps modulo 2^20.

Top module: `xta_unit`

## Requirements
- R1: Input `ifld` holds the fields of one instruction: n at bit 25, i at bit 24, x at bit 23, b at bit 22, p at bit 21, e at bit 20, the 12-bit displacement at [19:8] and the 20-bit long address at [19:0]. `out_len4` is 1 (4-byte instruction) exactly when e=1 and at least one of n, i is 1. Otherwise it is 0 (3 bytes).
- R2: When b=0 and p=0 and n|i=1, the target address is the zero-extended displacement (e=0) or the 20-bit long address (e=1).
- R3: When p=1, b=0 and e=0, the target address is `pc` + 3 + the sign-extended 12-bit displacement.
- R4: When b=1, p=0 and e=0, the target address is `breg` + the displacement, treated as unsigned.
- R5: When x=1, `xreg` is added into the target address in every mode.
- R6: When i=1 and n=0, `out_imm`=1, `out_eff` equals the target address, and no memory request is issued.
- R7: When n=1 and i=0, exactly one read request is issued with `mem_req_addr` equal to the target address. `out_eff` then equals `mem_rsp_data`, and `out_ind`=1.
- R8: When n=1 and i=1, `out_eff` equals the target address, `out_imm`=`out_ind`=0, and no request is issued.
- R9: When n=0 and i=0, the target address is `ifld[22:8]` (15 bits, zero-extended) plus X when x=1. The length is 3, no illegal flag is raised, and the operand is handled as in R8.
- R10: When n|i=1 and either b=p=1 or e=1 together with b or p, `out_bad`=1, `out_ta`=`out_eff`=0, `out_imm`=`out_ind`=0, and no request is issued.
- R11: Every address sum wraps modulo 2^20.
- R12: `in_ready` is high only while no instruction is in flight. `out_*` stay stable while `out_valid`=1 and `out_ready`=0. `mem_req_addr` stays stable while `mem_req_valid`=1 and `mem_req_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction accepted this cycle if valid |
| ifld | input | 26 | Flag bits and address fields (layout in R1) |
| pc | input | ADDR_W (20) | Address of the instruction's first byte |
| breg | input | ADDR_W (20) | Base register, low bits |
| xreg | input | ADDR_W (20) | Index register, low bits |
| mem_req_valid | output | 1 | Indirect read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W (20) | Word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ADDR_W (20) | Low bits of the word read |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts result |
| out_len4 | output | 1 | 1 = 4-byte instruction, 0 = 3-byte |
| out_ta | output | ADDR_W (20) | Target address |
| out_eff | output | ADDR_W (20) | Immediate value or operand address |
| out_imm | output | 1 | Operand is immediate |
| out_ind | output | 1 | Operand address came through indirection |
| out_bad | output | 1 | Illegal addressing flags |

## Verification
The bench aims at three sign and wrap cases:
- A PC-relative displacement of 0xFFF must step back one byte from the next instruction; a design that zero-extended it would land 4 KB ahead.
- A base-relative displacement of 0x800 must count forward, so a sign-extending design would move 2 KB backwards.
- A PC near the top of the address space must wrap to a low address rather than carry out.

It also covers the legacy decode: a design that kept reading b, p and e as flags when n=i=0 would report a 4-byte length or an illegal mode, or would drop high address bits.

It stalls the request and result handshakes and counts memory requests per instruction. This exposes a design that fetches for immediate, simple or illegal forms, or that loses data while stalled.

// File: rtl/xta_pkg.sv
package xta_pkg;
  localparam int FLD_W     = 26;
  localparam int DISP_W    = 12;
  localparam int LONG_W    = 20;
  localparam int LEG_W     = 15;
  localparam int SHORT_LEN = 3;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } xta_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } xta_state_t;
endpackage

// File: rtl/xta_decode.sv
module xta_decode
  import xta_pkg::*;
(
  input  logic [FLD_W-1:0]  ifld,
  output xta_flags_t        flg,
  output logic              legacy,
  output logic              len4,
  output logic              bad,
  output logic              imm,
  output logic              ind,
  output logic [DISP_W-1:0] disp,
  output logic [LONG_W-1:0] longa,
  output logic [LEG_W-1:0]  leg
);
  always_comb begin
    flg    = ifld[FLD_W-1 -: 6];
    legacy = !flg.n && !flg.i;
    len4   = flg.e && !legacy;
    bad    = !legacy && ((flg.b && flg.p) || (flg.e && (flg.b || flg.p)));
    imm    = flg.i && !flg.n;
    ind    = flg.n && !flg.i;
    disp   = ifld[LONG_W-1 -: DISP_W];
    longa  = ifld[LONG_W-1:0];
    leg    = ifld[LONG_W+2 -: LEG_W];
  end
endmodule

// File: rtl/xta_sum.sv
module xta_sum
  import xta_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  xta_flags_t        flg,
  input  logic              legacy,
  input  logic [DISP_W-1:0] disp,
  input  logic [LONG_W-1:0] longa,
  input  logic [LEG_W-1:0]  leg,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] breg,
  input  logic [ADDR_W-1:0] xreg,
  output logic [ADDR_W-1:0] ta
);
  logic [ADDR_W-1:0] base, offs, idx;

  always_comb begin
    idx = flg.x ? xreg : '0;
    if (legacy) begin
      base = '0;
      offs = ADDR_W'(leg);
    end else if (flg.e) begin
      base = '0;
      offs = ADDR_W'(longa);
    end else if (flg.p) begin
      base = pc + ADDR_W'(SHORT_LEN);
      offs = ADDR_W'($signed(disp));
    end else if (flg.b) begin
      base = breg;
      offs = ADDR_W'(disp);
    end else begin
      base = '0;
      offs = ADDR_W'(disp);
    end
    ta = base + offs + idx;
  end
endmodule

// File: rtl/xta_seq.sv
module xta_seq
  import xta_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              len4,
  input  logic              bad,
  input  logic              imm,
  input  logic              ind,
  input  logic [ADDR_W-1:0] ta,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_len4,
  output logic [ADDR_W-1:0] out_ta,
  output logic [ADDR_W-1:0] out_eff,
  output logic              out_imm,
  output logic              out_ind,
  output logic              out_bad
);
  xta_state_t        state;
  logic [ADDR_W-1:0] ta_q, eff_q;
  logic              len4_q, imm_q, ind_q, bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ta_q   <= '0;
      eff_q  <= '0;
      len4_q <= 1'b0;
      imm_q  <= 1'b0;
      ind_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          len4_q <= len4;
          bad_q  <= bad;
          imm_q  <= imm && !bad;
          ind_q  <= ind && !bad;
          ta_q   <= bad ? '0 : ta;
          eff_q  <= bad ? '0 : ta;
          state  <= (ind && !bad) ? ST_REQ : ST_DONE;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          eff_q <= mem_rsp_data;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ta_q;
  assign out_valid     = (state == ST_DONE);
  assign out_len4      = len4_q;
  assign out_ta        = ta_q;
  assign out_eff       = eff_q;
  assign out_imm       = imm_q;
  assign out_ind       = ind_q;
  assign out_bad       = bad_q;
endmodule

// File: rtl/xta_unit.sv
module xta_unit
  import xta_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLD_W-1:0]  ifld,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] breg,
  input  logic [ADDR_W-1:0] xreg,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_len4,
  output logic [ADDR_W-1:0] out_ta,
  output logic [ADDR_W-1:0] out_eff,
  output logic              out_imm,
  output logic              out_ind,
  output logic              out_bad
);
  xta_flags_t        flg;
  logic              legacy, len4, bad, imm, ind;
  logic [DISP_W-1:0] disp;
  logic [LONG_W-1:0] longa;
  logic [LEG_W-1:0]  leg;
  logic [ADDR_W-1:0] ta;

  xta_decode u_dec (
    .ifld(ifld), .flg(flg), .legacy(legacy), .len4(len4), .bad(bad),
    .imm(imm), .ind(ind), .disp(disp), .longa(longa), .leg(leg)
  );

  xta_sum #(.ADDR_W(ADDR_W)) u_sum (
    .flg(flg), .legacy(legacy), .disp(disp), .longa(longa), .leg(leg),
    .pc(pc), .breg(breg), .xreg(xreg), .ta(ta)
  );

  xta_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .len4(len4), .bad(bad), .imm(imm), .ind(ind), .ta(ta),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_len4(out_len4), .out_ta(out_ta), .out_eff(out_eff),
    .out_imm(out_imm), .out_ind(out_ind), .out_bad(out_bad)
  );
endmodule

// File: rtl/xta_unit_chk.sv
module xta_unit_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        ni,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_len4,
  input logic [ADDR_W-1:0] out_ta,
  input logic [ADDR_W-1:0] out_eff,
  input logic              out_imm,
  input logic              out_ind,
  input logic              out_bad
);
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ta) && $stable(out_eff)
      && $stable(out_len4) && $stable(out_imm) && $stable(out_ind) && $stable(out_bad));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid && !mem_req_valid);

  // R6
  imm_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && ni == 2'b01 |=> !mem_req_valid);

  // R10
  bad_clear_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_bad |-> out_ta == '0 && out_eff == '0 && !out_imm && !out_ind);

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_imm && out_ind));
endmodule

bind xta_unit xta_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .ni(ifld[25:24]), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_len4(out_len4), .out_ta(out_ta), .out_eff(out_eff),
  .out_imm(out_imm), .out_ind(out_ind), .out_bad(out_bad)
);

// File: tb/xta_unit_bench.sv
module xta_unit_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [25:0]   ifld = '0;
  logic [AW-1:0] pc = '0, breg = '0, xreg = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_len4, out_imm, out_ind, out_bad;
  logic [AW-1:0] out_ta, out_eff;

  int checks = 0;
  int fails = 0;
  int reqs = 0;
  int reqs_seen = 0;
  int cyc = 0;

  typedef struct {
    string         name;
    logic          len4;
    logic [AW-1:0] ta;
    logic [AW-1:0] eff;
    logic          imm;
    logic          ind;
    logic          bad;
    int            nreq;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  xta_unit #(.ADDR_W(AW)) u_xta_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .ifld(ifld),
    .pc(pc), .breg(breg), .xreg(xreg), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_len4(out_len4),
    .out_ta(out_ta), .out_eff(out_eff), .out_imm(out_imm), .out_ind(out_ind),
    .out_bad(out_bad)
  );

  function automatic logic [AW-1:0] mem_fn(input logic [AW-1:0] a);
    return a ^ 20'h5A5A5;
  endfunction

  // memory model and stall patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
    out_ready     <= (cyc % 5) != 2;
    if (mem_req_valid && mem_req_ready) begin
      reqs          <= reqs + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_fn(mem_req_addr);
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, $sformatf("R12 unexpected result ta=%h", out_ta));
      end else begin
        exp_t e;
        int   n;
        e = sb.pop_front();
        n = reqs - reqs_seen;
        reqs_seen = reqs;
        check(out_len4 == e.len4 && out_ta == e.ta && out_eff == e.eff &&
              out_imm == e.imm && out_ind == e.ind && out_bad == e.bad,
              $sformatf("%s: got len4=%0d ta=%h eff=%h imm=%0d ind=%0d bad=%0d exp len4=%0d ta=%h eff=%h imm=%0d ind=%0d bad=%0d",
                        e.name, out_len4, out_ta, out_eff, out_imm, out_ind, out_bad,
                        e.len4, e.ta, e.eff, e.imm, e.ind, e.bad));
        check(n == e.nreq, $sformatf("%s: memory requests got %0d exp %0d", e.name, n, e.nreq));
      end
    end
  end

  task automatic send(input string name, input logic n, i, x, b, p, e,
                      input logic [19:0] low, input logic [AW-1:0] pcv, bv, xv);
    exp_t          ex;
    logic [AW-1:0] idx, ta;
    logic [11:0]   d;
    logic          bad, legacy;
    d      = low[19:8];
    idx    = x ? xv : '0;
    legacy = !n && !i;
    bad    = !legacy && ((b && p) || (e && (b || p)));
    if (legacy)      ta = AW'({b, p, e, d}) + idx;
    else if (e)      ta = low + idx;
    else if (p)      ta = pcv + 20'd3 + {{8{d[11]}}, d} + idx;
    else if (b)      ta = bv + {8'h00, d} + idx;
    else             ta = {8'h00, d} + idx;
    ex.name = name;
    ex.len4 = e && !legacy;
    ex.bad  = bad;
    ex.imm  = !bad && i && !n;
    ex.ind  = !bad && n && !i;
    ex.ta   = bad ? '0 : ta;
    ex.eff  = bad ? '0 : (ex.ind ? mem_fn(ta) : ta);
    ex.nreq = ex.ind ? 1 : 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    ifld = {n, i, x, b, p, e, low};
    pc = pcv; breg = bv; xreg = xv;
    in_valid = 1'b1;
    sb.push_back(ex);
    @(negedge clk);
    in_valid = 1'b0;
    ifld = '1; pc = '1; breg = '1; xreg = '1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "R12 watchdog expired, actual hung exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(in_ready == 1'b1, $sformatf("R12 reset in_ready got %0d exp 1", in_ready));
    check(out_valid == 1'b0, $sformatf("R12 reset out_valid got %0d exp 0", out_valid));
    check(mem_req_valid == 1'b0, $sformatf("R7 reset mem_req_valid got %0d exp 0", mem_req_valid));

    send("R2 simple short direct",   1,1,0,0,0,0, 20'h345EE, 20'h01000, 20'h00000, 20'h00000);
    send("R3 pc-relative forward",   1,1,0,0,1,0, 20'h07FEE, 20'h01000, 20'h00000, 20'h00000);
    send("R3 pc-relative back one",  1,1,0,0,1,0, 20'hFFF00, 20'h01000, 20'h00000, 20'h00000);
    send("R4 base unsigned 0x800",   1,1,0,1,0,0, 20'h80011, 20'h01000, 20'h20000, 20'h00000);
    send("R5 indexed base",          1,1,1,1,0,0, 20'h01000, 20'h01000, 20'h20000, 20'h00444);
    send("R1 R2 long direct",        1,1,0,0,0,1, 20'hABCDE, 20'h01000, 20'h00000, 20'h00000);
    send("R5 long indexed",          1,1,1,0,0,1, 20'h10000, 20'h01000, 20'h00000, 20'h00777);
    send("R6 immediate short",       0,1,0,0,0,0, 20'h12300, 20'h01000, 20'h00000, 20'h00000);
    send("R6 R1 immediate long",     0,1,0,0,0,1, 20'hFEDCB, 20'h01000, 20'h00000, 20'h00000);
    send("R7 indirect pc-relative",  1,0,0,0,1,0, 20'h01000, 20'h02000, 20'h00000, 20'h00000);
    send("R7 R5 indirect indexed",   1,0,1,0,0,0, 20'h05000, 20'h01000, 20'h00000, 20'h00010);
    send("R8 simple base",           1,1,0,1,0,0, 20'h00100, 20'h01000, 20'h0ABC0, 20'h00000);
    send("R9 legacy 15-bit address", 0,0,0,1,1,1, 20'h23400, 20'h01000, 20'h00000, 20'h00000);
    send("R9 legacy indexed",        0,0,1,1,0,0, 20'hFFF00, 20'h01000, 20'h00000, 20'h00005);
    send("R10 illegal b and p",      1,1,0,1,1,0, 20'h12300, 20'h01000, 20'h20000, 20'h00000);
    send("R10 illegal long with p",  0,1,0,0,1,1, 20'h12345, 20'h01000, 20'h00000, 20'h00000);
    send("R10 illegal long with b",  1,0,0,1,0,1, 20'h12345, 20'h01000, 20'h00000, 20'h00000);
    send("R11 pc wrap",              1,1,0,0,1,0, 20'h00400, 20'hFFFFE, 20'h00000, 20'h00000);
    send("R11 base plus index wrap", 1,1,1,1,0,0, 20'hFFF00, 20'h01000, 20'hFFF00, 20'h00200);

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule